// File: doc/BRIEF.md
# Processor Core Power-Up Sequencer

This block is a hardware state machine that takes an embedded processor core from a cold state to running. In the cold state the core is clamped, held in reset and has its memories switched off. A single-cycle `start` pulse launches a fixed sequence:

1. Assert the core, bus and stop-core controls.
2. Enable the crystal-oscillator clock branch and wait until its clock-off status reads low.
3. Close the block headswitch and, one microsecond later, put the LDO into bypass.
4. Release the memory clamps and retention controls.
5. Power the twenty memory banks one at a time, from the top bank down.
6. Drop the word-line clamp, then the IO clamp.
7. Release core reset, enable the core clock, and finally let the core run.

The analog switches, the processor and the register bus are outside this block. Each one is only a plain port here.

All waits are counted in microseconds. The length of one microsecond is set by the `cyc_per_us` input, in clock cycles; a value of 0 is treated as 1. If the clock branch still reports "off" after 200 checks spaced one microsecond apart, the sequencer stops and raises `err`. It then freezes every output at the value it had when the error occurred. `done` and `err` stay set until the next `start`. A `start` pulse that arrives while a sequence is running has no effect. The bus reset output is asserted by the sequence and is left asserted; releasing it is up to other logic.

Top module: `core_pwrup_seq`

## Requirements
- R1: In the cycle after synchronous reset, the following hold: `core_rst`, `bus_rst` and `stop_core` are 1; `xo_clk_en` and `core_clk_en` are 0; `pwr_ctl` bits 20, 21 and 22 (IO, word-line and compiler-memory clamps) are 1 and all other `pwr_ctl` bits are 0; `bank_pwr` is 0; `done` and `err` are 0.
- R2: A start pulse first asserts `core_rst`, `bus_rst` and `stop_core` together, and then sets `xo_clk_en`. No other output changes in between.
- R3: After `xo_clk_en` is set, `clkoff_sts` is checked once per microsecond. A low reading lets the sequence continue. If 200 checks in a row read high, `err` is set, and that happens no earlier than 200 microseconds after `xo_clk_en` rose.
- R4: Headswitch (`pwr_ctl` bit 24) is set next. LDO bypass (bit 25) is set at least one microsecond later.
- R5: The compiler-memory clamp (bit 22) is then cleared. After that, L2 standby_n (bit 18) and sleep retention_n (bit 19) are set, both in the same cycle.
- R6: The banks in `bank_pwr` are then turned on one bit at a time, in the order 19, 18, …, 0. Each bit turns on at least one microsecond after the previous one, and no bank is turned off.
- R7: The word-line clamp (bit 21) is then cleared, followed by the IO clamp (bit 20).
- R8: The last three steps are, in this order: clear `core_rst`, set `core_clk_en`, clear `stop_core`. `done` rises together with the clearing of `stop_core`.
- R9: A start pulse while a sequence is running is ignored. The run completes in the same number of cycles as an undisturbed run.
- R10: `done` and `err` stay set until the next start pulse and are cleared in the cycle after it. While `err` is set, all outputs hold.
- R11: A microsecond is `cyc_per_us` cycles, and a value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle launch pulse |
| cyc_per_us | input | CW | Clock cycles per microsecond |
| clkoff_sts | input | 1 | Clock branch reports off when high |
| core_rst | output | 1 | Core reset, active high |
| bus_rst | output | 1 | Bus reset, active high |
| stop_core | output | 1 | Holds core execution when high |
| xo_clk_en | output | 1 | Oscillator clock branch enable |
| core_clk_en | output | 1 | Core clock enable |
| pwr_ctl | output | 32 | Power controls; bits 18..25 as in R1, R4, R5 and R7, other bits 0 |
| bank_pwr | output | NBANK | Memory bank power enables |
| done | output | 1 | Sequence completed (sticky) |
| err | output | 1 | Clock check timed out (sticky) |

## Verification
The control outputs are packed into one vector, and every cycle that vector is compared with an ordered list of permitted changes. Any out-of-order step, skipped step or merged step is therefore caught, whatever the pacing.

Random runs vary the microsecond length and how long the clock branch stays off. This checks that the ordering holds for every timing, and that each wait lasts at least one microsecond.

Directed runs cover the following cases:
- A clock branch that never turns on, which separates a timed-out run from a late-but-successful one and checks that outputs freeze on error.
- A start pulse in the middle of the bank ladder, which would show up as a longer run if it were not ignored.
- A `cyc_per_us` of zero.
- A restart after completion.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int unsigned PB_STBY_N = 18;
  localparam int unsigned PB_SLPRET_N = 19;
  localparam int unsigned PB_IO_CLAMP = 20;
  localparam int unsigned PB_WL_CLAMP = 21;
  localparam int unsigned PB_QMC_CLAMP = 22;
  localparam int unsigned PB_HDSW = 24;
  localparam int unsigned PB_LDO_BYP = 25;

  typedef enum logic [4:0] {
    S_IDLE, S_RESETS, S_XO, S_POLL, S_HS, S_HS_WAIT, S_LDO, S_QMC,
    S_STBY, S_BANK_SET, S_BANK_WAIT, S_WL, S_IO, S_CORE, S_CLK, S_RUN, S_ERR
  } seq_state_t;
endpackage

// File: rtl/pwrseq_us_timer.sv
module pwrseq_us_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] cyc_per_us,
  output logic          tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = (cyc_per_us == '0) ? CW'(1) : cyc_per_us;
  assign tick  = run && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/pwrseq_bank_ladder.sv
module pwrseq_bank_ladder #(
  parameter int unsigned NB = 20,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          set_bit,
  input  logic          step_down,
  output logic [NB-1:0] bank,
  output logic          at_bottom
);
  logic [IW-1:0] idx;

  assign at_bottom = (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= IW'(NB - 1);
      bank <= '0;
    end else begin
      if (arm)            idx <= IW'(NB - 1);
      else if (step_down) idx <= idx - IW'(1);
      if (set_bit)        bank[idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
  import pwrseq_pkg::*;
#(
  parameter int unsigned NBANK = 20,
  parameter int unsigned CW = 16,
  parameter int unsigned MAX_POLLS = 200,
  localparam int unsigned PW = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CW-1:0]    cyc_per_us,
  input  logic             clkoff_sts,
  output logic             core_rst,
  output logic             bus_rst,
  output logic             stop_core,
  output logic             xo_clk_en,
  output logic             core_clk_en,
  output logic [31:0]      pwr_ctl,
  output logic [NBANK-1:0] bank_pwr,
  output logic             done,
  output logic             err
);
  seq_state_t    st;
  logic [PW-1:0] polls;
  logic          tick, timer_run, at_bottom, parked;
  logic          stby_n, slpret_n, io_cl, wl_cl, qmc_cl, hdsw, ldo_byp;
  logic          chk_en;

  assign parked    = (st == S_IDLE) || (st == S_ERR);
  assign timer_run = (st == S_POLL) || (st == S_HS_WAIT) || (st == S_BANK_WAIT);

  pwrseq_us_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .run(timer_run), .cyc_per_us(cyc_per_us), .tick(tick)
  );

  pwrseq_bank_ladder #(.NB(NBANK)) u_ladder (
    .clk(clk), .rst(rst),
    .arm(st == S_STBY),
    .set_bit(st == S_BANK_SET),
    .step_down((st == S_BANK_WAIT) && tick && !at_bottom),
    .bank(bank_pwr), .at_bottom(at_bottom)
  );

  always_comb begin
    pwr_ctl = '0;
    pwr_ctl[PB_STBY_N]    = stby_n;
    pwr_ctl[PB_SLPRET_N]  = slpret_n;
    pwr_ctl[PB_IO_CLAMP]  = io_cl;
    pwr_ctl[PB_WL_CLAMP]  = wl_cl;
    pwr_ctl[PB_QMC_CLAMP] = qmc_cl;
    pwr_ctl[PB_HDSW]      = hdsw;
    pwr_ctl[PB_LDO_BYP]   = ldo_byp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      polls <= '0;
      core_rst <= 1'b1; bus_rst <= 1'b1; stop_core <= 1'b1;
      xo_clk_en <= 1'b0; core_clk_en <= 1'b0;
      stby_n <= 1'b0; slpret_n <= 1'b0; hdsw <= 1'b0; ldo_byp <= 1'b0;
      io_cl <= 1'b1; wl_cl <= 1'b1; qmc_cl <= 1'b1;
      done <= 1'b0; err <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_ERR: if (start) begin
          done <= 1'b0; err <= 1'b0; st <= S_RESETS;
        end
        S_RESETS: begin
          core_rst <= 1'b1; bus_rst <= 1'b1; stop_core <= 1'b1; st <= S_XO;
        end
        S_XO: begin xo_clk_en <= 1'b1; polls <= '0; st <= S_POLL; end
        S_POLL: if (tick) begin
          if (!clkoff_sts) st <= S_HS;
          else if (polls == PW'(MAX_POLLS - 1)) begin err <= 1'b1; st <= S_ERR; end
          else polls <= polls + PW'(1);
        end
        S_HS:        begin hdsw <= 1'b1; st <= S_HS_WAIT; end
        S_HS_WAIT:   if (tick) st <= S_LDO;
        S_LDO:       begin ldo_byp <= 1'b1; st <= S_QMC; end
        S_QMC:       begin qmc_cl <= 1'b0; st <= S_STBY; end
        S_STBY:      begin stby_n <= 1'b1; slpret_n <= 1'b1; st <= S_BANK_SET; end
        S_BANK_SET:  st <= S_BANK_WAIT;
        S_BANK_WAIT: if (tick) st <= at_bottom ? S_WL : S_BANK_SET;
        S_WL:        begin wl_cl <= 1'b0; st <= S_IO; end
        S_IO:        begin io_cl <= 1'b0; st <= S_CORE; end
        S_CORE:      begin core_rst <= 1'b0; st <= S_CLK; end
        S_CLK:       begin core_clk_en <= 1'b1; st <= S_RUN; end
        S_RUN:       begin stop_core <= 1'b0; done <= 1'b1; st <= S_IDLE; end
        default:     st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) chk_en <= !rst;

  AST_BANK_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst || !chk_en)
    (bank_pwr != $past(bank_pwr)) |-> ($countones(bank_pwr) == $countones($past(bank_pwr)) + 1)
      && (($past(bank_pwr) & ~bank_pwr) == '0)); // R6
  AST_LDO_AFTER_HDSW: assert property (@(posedge clk) disable iff (rst || !chk_en)
    $rose(ldo_byp) |-> $past(hdsw)); // R4
  AST_RUN_RELEASE_LAST: assert property (@(posedge clk) disable iff (rst || !chk_en)
    $fell(stop_core) |-> !core_rst && core_clk_en && !io_cl && !wl_cl && done); // R8
  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (rst || !chk_en)
    (err && $past(err)) |-> $stable(bank_pwr) && $stable(pwr_ctl) && $stable(core_rst)
      && $stable(stop_core) && $stable(xo_clk_en) && $stable(core_clk_en)); // R10
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R10
  AST_STBY_AFTER_QMC: assert property (@(posedge clk) disable iff (rst || !chk_en)
    $rose(stby_n) |-> !qmc_cl && $rose(slpret_n)); // R5
endmodule

// File: tb/core_pwrup_seq_test.sv
module core_pwrup_seq_test;
  localparam int NB = 20;
  localparam int CW = 16;
  localparam int NSTEP = 31;

  logic clk = 0, rst = 1, start = 0, clkoff_sts = 1;
  logic [CW-1:0] cyc_per_us = 16'd2;
  logic core_rst, bus_rst, stop_core, xo_clk_en, core_clk_en, done, err;
  logic [31:0] pwr_ctl;
  logic [NB-1:0] bank_pwr;

  int n_chk = 0, n_bad = 0;
  logic [32:0] exp_list [NSTEP];

  core_pwrup_seq uut (
    .clk(clk), .rst(rst), .start(start), .cyc_per_us(cyc_per_us), .clkoff_sts(clkoff_sts),
    .core_rst(core_rst), .bus_rst(bus_rst), .stop_core(stop_core), .xo_clk_en(xo_clk_en),
    .core_clk_en(core_clk_en), .pwr_ctl(pwr_ctl), .bank_pwr(bank_pwr), .done(done), .err(err)
  );

  always #10 clk = ~clk;

  // vector: {core_rst, bus_rst, stop_core, xo, core_clk, pwr_ctl[25:18], bank[19:0]}
  function automatic logic [32:0] pack_out();
    return {core_rst, bus_rst, stop_core, xo_clk_en, core_clk_en, pwr_ctl[25:18], bank_pwr};
  endfunction

  // pwr byte bit i = pwr_ctl[18+i]
  function automatic void build_list();
    logic [32:0] v;
    v = '0;
    v[32] = 1; v[31] = 1; v[30] = 1;
    v[20 + 2] = 1; v[20 + 3] = 1; v[20 + 4] = 1; // IO, WL, QMC clamps
    exp_list[0] = v;
    v[29] = 1;       exp_list[1] = v;  // xo
    v[20 + 6] = 1;   exp_list[2] = v;  // headswitch
    v[20 + 7] = 1;   exp_list[3] = v;  // ldo bypass
    v[20 + 4] = 0;   exp_list[4] = v;  // qmc clamp off
    v[20 + 0] = 1; v[20 + 1] = 1; exp_list[5] = v; // stby_n, slpret_n
    for (int b = 19; b >= 0; b--) begin v[b] = 1; exp_list[6 + 19 - b] = v; end
    v[20 + 3] = 0;   exp_list[26] = v; // wl clamp off
    v[20 + 2] = 0;   exp_list[27] = v; // io clamp off
    v[32] = 0;       exp_list[28] = v; // core reset off
    v[28] = 1;       exp_list[29] = v; // core clock on
    v[30] = 0;       exp_list[30] = v; // run
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    rst = 1; start = 0; clkoff_sts = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(pack_out() == exp_list[0] && pwr_ctl[31:26] == 0 && pwr_ctl[17:0] == 0
          && !done && !err, "R1 reset state", pack_out(), exp_list[0]);
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  // d: cycles clkoff stays high after xo seen; mid: start pulse inside the ladder
  task automatic run_seq(input int c, input int d, input bit mid, input string tag,
                         output int len, output bit got_done, output bit got_err);
    int k, cyc, xo_cnt, t_hs, t_ldo, t_bank, t_xo, min_gap, ceff;
    bit order_ok, mid_done;
    logic [32:0] v;
    ceff = (c == 0) ? 1 : c;
    cyc_per_us = CW'(c);
    do_reset();
    pulse_start();
    k = 0; cyc = 1; xo_cnt = 0; t_hs = -1; t_ldo = -1; t_bank = -1; t_xo = -1;
    min_gap = 1 << 30; order_ok = 1; mid_done = 0;
    got_done = 0; got_err = 0;
    while (cyc < 60000) begin
      v = pack_out();
      if (v != exp_list[k]) begin
        if (k + 1 < NSTEP && v == exp_list[k + 1]) begin
          k++;
          if (k == 1) t_xo = cyc;
          if (k == 2) t_hs = cyc;
          if (k == 3) t_ldo = cyc;
          if (k >= 6 && k <= 25) begin
            if (t_bank >= 0 && cyc - t_bank < min_gap) min_gap = cyc - t_bank;
            t_bank = cyc;
          end
        end else if (order_ok) begin
          order_ok = 0;
          check(0, {tag, " R2 R5 R7 R8 step order"}, v, exp_list[k + 1 < NSTEP ? k + 1 : k]);
        end
      end
      if (done) begin got_done = 1; break; end
      if (err) begin got_err = 1; break; end
      if (xo_clk_en) xo_cnt++;
      clkoff_sts = (xo_cnt <= d);
      start = (mid && !mid_done && k == 12);
      if (start) mid_done = 1;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    len = cyc;
    if (got_done) begin
      check(k == NSTEP - 1, {tag, " R8 all steps reached before done"}, k, NSTEP - 1);
      check(t_ldo - t_hs >= ceff, {tag, " R4 R11 headswitch to LDO gap"}, t_ldo - t_hs, ceff);
      check(min_gap >= ceff, {tag, " R6 R11 bank spacing"}, min_gap, ceff);
    end
    if (got_err)
      check(cyc - t_xo >= 200 * ceff, {tag, " R3 timeout not early"}, cyc - t_xo, 200 * ceff);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len0, len1;
    bit gd, ge;
    logic [32:0] held;
    build_list();
    void'($urandom(32'h1A2B3C4D));

    // directed: nominal
    run_seq(2, 7, 0, "nominal", len0, gd, ge);
    check(gd && !ge, "R2 nominal run completes", gd, 1);
    // R9: mid-run start ignored
    run_seq(2, 7, 1, "midstart", len1, gd, ge);
    check(gd, "R9 run completes with stray start", gd, 1);
    check(len1 == len0, "R9 stray start leaves run length unchanged", len1, len0);
    // R10 done sticky then cleared by start
    repeat (40) @(negedge clk);
    check(done && !err, "R10 done sticky", done, 1);
    pulse_start();
    check(!done, "R10 done cleared by start", done, 0);
    repeat (5000) begin
      @(negedge clk);
      if (done) break;
    end
    check(done && stop_core == 0 && core_rst == 0, "R8 restart from done completes", done, 1);
    // R11 zero cycles per microsecond
    run_seq(0, 3, 0, "zero_us", len0, gd, ge);
    check(gd, "R11 zero acts as one", gd, 1);
    // R3 late but within limit: 150 checks at c=1
    run_seq(1, 150, 0, "late_clk", len0, gd, ge);
    check(gd && !ge, "R3 late clock accepted", gd, 1);
    // R3 never on -> error
    run_seq(2, 1 << 30, 0, "no_clk", len0, gd, ge);
    check(ge && !gd, "R3 timeout error raised", ge, 1);
    held = pack_out();
    check(held == exp_list[1], "R3 error stops before headswitch", held, exp_list[1]);
    repeat (50) @(negedge clk);
    check(pack_out() == held && err && !done, "R10 outputs frozen on error", pack_out(), held);
    pulse_start();
    check(!err, "R10 err cleared by start", err, 0);

    // random runs
    for (int i = 0; i < 8; i++) begin
      int c, d;
      c = 1 + ($urandom % 5);
      d = $urandom % 60;
      run_seq(c, d, 0, "random", len0, gd, ge);
      check(gd && !ge, "R6 random run completes", gd, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule